// File: doc/BRIEF.md
# Bus Controller Interrupt Status and Vector Unit

This unit gathers the event flags raised by the transfer engine of a serial-bus master and presents them to software through a small register port. Each single-cycle event pulse sets a sticky flag in a 16-bit status word. Software acknowledges a flag by writing a 1 to its bit. A 5-bit enable word selects which of the five transfer events drive one level-sensitive interrupt line.

For software written against the older numeric scheme, a vector register returns a small code instead of a bitmask. The code names the most urgent enabled event that is pending. Reading the vector also acknowledges the event it names, so repeated reads step through every pending event in priority order.

The bus-busy level is not a sticky flag. It appears in the status word as a live copy of its input, so software can poll it before starting a transfer. Register addresses are 0 for status, 1 for enable and 2 for vector. Address 3 is unmapped.

Top module: `bus_irq_status`

## Requirements
- R1: After reset the status word, the enable word, the vector code and `irqOut` are all zero.
- R2: At address 1, bits 4..0 of a write are stored as the enable word. A read returns them in bits 4..0, with bits 15..5 reading zero.
- R3: An event pulse sets its status bit, which reads back on the cycle after the pulse. The bit positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow, 11 receive overrun.
- R4: A write to address 0 clears each sticky bit written as 1 and leaves bits written as 0 unchanged. Writing back a value just read clears every flag that value showed.
- R5: Status bit 12 follows the bus-busy input in the same cycle and ignores writes. Bits 15..13, 9..5 always read zero.
- R6: `irqOut` is high exactly while some status bit in 4..0 is set together with the matching enable bit. The overrun and underflow bits never drive it.
- R7: Address 2 reads a code in bits 2..0: 0 if no enabled event in bits 4..0 is pending, otherwise the lowest code among those pending. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready and 5 transmit ready. Pending events that are disabled are skipped.
- R8: A read of address 2 that returns a nonzero code clears the status bit behind that code at the end of the read cycle.
- R9: If an event pulse and a clear reach the same bit in the same cycle, the bit stays set. The clear may come from a status write or from a vector read.
- R10: Address 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect only at address 2) |
| regAddr | input | ADDR_W (2) | Register address |
| regWrData | input | DATA_W (16) | Write data |
| regRdData | output | DATA_W (16) | Read data, combinational from the address |
| evtArbLost | input | 1 | Arbitration-lost pulse |
| evtNoAck | input | 1 | No-acknowledge pulse |
| evtAccRdy | input | 1 | Access-ready pulse |
| evtRxRdy | input | 1 | Receive-ready pulse |
| evtTxRdy | input | 1 | Transmit-ready pulse |
| evtOverrun | input | 1 | Receive-overrun pulse |
| evtUnderflow | input | 1 | Transmit-underflow pulse |
| busBusy | input | 1 | Live bus-busy level |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions check four things on every cycle:
- Any event pulse leaves its flag set on the next cycle, even when a clear hits the same bit.
- A status write leaves no written-1 flag set unless an event refilled it.
- A vector read with a pending code removes exactly one flag.
- The interrupt rises after an enabled event, stays low while every enable is off, and the vector code never exceeds 5.

Some behaviours only the directed scenarios can show: the numeric codes and the order in which repeated vector reads walk through them, the skipping of disabled events, the live bus-busy bit, write-back acknowledgement, and the silence of the unmapped address.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  // Status bit positions; bits 4..0 line up with the enable word and the
  // vector code of bit i is i+1.
  localparam int BIT_ARBLOST = 0;
  localparam int BIT_NOACK   = 1;
  localparam int BIT_ACCRDY  = 2;
  localparam int BIT_RXRDY   = 3;
  localparam int BIT_TXRDY   = 4;
  localparam int BIT_UNDERFL = 10;
  localparam int BIT_OVERRUN = 11;
  localparam int BIT_BUSY    = 12;

  // Register map
  localparam int ADR_STATUS = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_VECTOR = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_VECTOR
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   enWr;
    logic   stWr;
    logic   vecRd;
    rdSel_e rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/bus_irq_ctrl.sv
module bus_irq_ctrl
  import bus_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStb_t          stb
);

  always_comb begin
    stb = '{enWr: 1'b0, stWr: 1'b0, vecRd: 1'b0, rdSel: SEL_NONE};
    case (regAddr)
      ADDR_W'(ADR_STATUS): begin
        stb.rdSel = SEL_STATUS;
        stb.stWr  = regWrEn;
      end
      ADDR_W'(ADR_ENABLE): begin
        stb.rdSel = SEL_ENABLE;
        stb.enWr  = regWrEn;
      end
      ADDR_W'(ADR_VECTOR): begin
        stb.rdSel = SEL_VECTOR;
        stb.vecRd = regRdEn;
      end
      default: ;
    endcase
  end

  // R10: at most one register is touched per access
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.enWr, stb.stWr, stb.vecRd}));

endmodule

// File: rtl/bus_irq_dp.sv
module bus_irq_dp
  import bus_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_VEC  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_VEC-1:0]  evtPulse,
  input  logic              evtOverrun,
  input  logic              evtUnderflow,
  input  logic              busyIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int VEC_W = $clog2(N_VEC + 1);
  localparam logic [DATA_W-1:0] STICKY_MASK =
      DATA_W'((1 << N_VEC) - 1) |
      (DATA_W'(1) << BIT_UNDERFL) |
      (DATA_W'(1) << BIT_OVERRUN);

  logic [DATA_W-1:0] statQ;
  logic [N_VEC-1:0]  enQ;
  logic [DATA_W-1:0] setMask;
  logic [DATA_W-1:0] clrMask;
  logic [N_VEC-1:0]  pend;
  logic [N_VEC-1:0]  vecHot;
  logic [VEC_W-1:0]  vecCode;

  always_comb begin
    setMask = '0;
    setMask[N_VEC-1:0]  = evtPulse;
    setMask[BIT_UNDERFL] = evtUnderflow;
    setMask[BIT_OVERRUN] = evtOverrun;
  end

  assign pend = statQ[N_VEC-1:0] & enQ;

  // Lowest set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    vecCode = '0;
    vecHot  = '0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vecCode   = VEC_W'(i + 1);
        vecHot    = '0;
        vecHot[i] = 1'b1;
      end
    end
  end

  always_comb begin
    clrMask = '0;
    if (stb.stWr) clrMask = wrData;
    if (stb.vecRd) clrMask[N_VEC-1:0] = clrMask[N_VEC-1:0] | vecHot;
  end

  // Set is applied after clear, so a same-cycle event keeps its bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enQ   <= '0;
    end else begin
      statQ <= ((statQ & ~clrMask) | setMask) & STICKY_MASK;
      if (stb.enWr) enQ <= wrData[N_VEC-1:0];
    end
  end

  assign irqOut = |pend;

  always_comb begin
    case (stb.rdSel)
      SEL_STATUS: rdData = statQ | (DATA_W'(busyIn) << BIT_BUSY);
      SEL_ENABLE: rdData = DATA_W'(enQ);
      SEL_VECTOR: rdData = DATA_W'(vecCode);
      default:    rdData = '0;
    endcase
  end

  // R3, R9: every event leaves its flag set, clear or not
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((statQ & $past(setMask)) == $past(setMask)));

  // R4: written ones are gone unless an event refilled them
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.stWr |=> ((statQ & $past(wrData & ~setMask)) == '0));

  // R8: a vector read with something pending removes exactly one flag
  p_vec_pops_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecRd && (pend != '0) && (setMask == '0)) |=>
      ($countones(statQ) == $countones($past(statQ)) - 1));

  // R6: an enabled event raises the line on the next cycle
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (((evtPulse & enQ) != '0) && !stb.enWr) |=> irqOut);

  // R6: no enables, no interrupt
  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);

  // R7: code stays within the defined range
  p_vec_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(vecCode) <= N_VEC));

endmodule

// File: rtl/bus_irq_status.sv
module bus_irq_status
  import bus_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtArbLost,
  input  logic              evtNoAck,
  input  logic              evtAccRdy,
  input  logic              evtRxRdy,
  input  logic              evtTxRdy,
  input  logic              evtOverrun,
  input  logic              evtUnderflow,
  input  logic              busBusy,
  output logic              irqOut
);

  localparam int N_VEC = BIT_TXRDY + 1;

  ctrlStb_t         stb;
  logic [N_VEC-1:0] evtPulse;

  assign evtPulse = {evtTxRdy, evtRxRdy, evtAccRdy, evtNoAck, evtArbLost};

  bus_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  bus_irq_dp #(.DATA_W(DATA_W), .N_VEC(N_VEC)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (regWrData),
    .evtPulse     (evtPulse),
    .evtOverrun   (evtOverrun),
    .evtUnderflow (evtUnderflow),
    .busyIn       (busBusy),
    .rdData       (regRdData),
    .irqOut       (irqOut)
  );

endmodule

// File: tb/bus_irq_status_tb_top.sv
module bus_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        evtArbLost = 0, evtNoAck = 0, evtAccRdy = 0, evtRxRdy = 0;
  logic        evtTxRdy = 0, evtOverrun = 0, evtUnderflow = 0, busBusy = 0;
  logic        irqOut;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  bus_irq_status dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtArbLost(evtArbLost), .evtNoAck(evtNoAck), .evtAccRdy(evtAccRdy),
    .evtRxRdy(evtRxRdy), .evtTxRdy(evtTxRdy), .evtOverrun(evtOverrun),
    .evtUnderflow(evtUnderflow), .busBusy(busBusy), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // mask order: {underflow, overrun, tx, rx, acc, noack, arblost}
  task automatic pulse(logic [6:0] m);
    {evtUnderflow, evtOverrun, evtTxRdy, evtRxRdy, evtAccRdy, evtNoAck, evtArbLost} = m;
    @(negedge clk);
    {evtUnderflow, evtOverrun, evtTxRdy, evtRxRdy, evtAccRdy, evtNoAck, evtArbLost} = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 status after reset", v, 16'h0000);
    rd(2'd1, v); chk("R1 enable after reset", v, 16'h0000);
    rd(2'd2, v); chk("R1 vector after reset", v, 16'h0000);
    chk("R1 irq after reset", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic t_enable;
    logic [15:0] v;
    wr(2'd1, 16'h0015); rd(2'd1, v); chk("R2 enable readback", v, 16'h0015);
    wr(2'd1, 16'hFFEA); rd(2'd1, v); chk("R2 enable upper bits dropped", v, 16'h000A);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_set_and_irq;
    logic [15:0] v;
    pulse(7'b0010000);
    rd(2'd0, v); chk("R3 tx ready sets bit 4", v, 16'h0010);
    chk("R6 irq low while disabled", {15'b0, irqOut}, 16'h0000);
    wr(2'd1, 16'h0010);
    chk("R6 irq high once enabled", {15'b0, irqOut}, 16'h0001);
    pulse(7'b0000110);
    rd(2'd0, v); chk("R3 noack and access bits", v, 16'h0016);
    // R4: zeros leave flags alone
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R4 zero write keeps flags", v, 16'h0016);
    wr(2'd0, 16'h0010); rd(2'd0, v); chk("R4 one clears bit 4", v, 16'h0006);
    chk("R6 irq drops after ack", {15'b0, irqOut}, 16'h0000);
    wr(2'd0, 16'h0006);
  endtask

  task automatic t_vector_walk;
    logic [15:0] v;
    wr(2'd1, 16'h001F);
    pulse(7'b0011111);
    rd(2'd2, v); chk("R7 vector arb lost first", v, 16'h0001);
    rd(2'd2, v); chk("R8 vector then noack", v, 16'h0002);
    rd(2'd2, v); chk("R8 vector then access", v, 16'h0003);
    rd(2'd2, v); chk("R8 vector then rx", v, 16'h0004);
    rd(2'd2, v); chk("R8 vector then tx", v, 16'h0005);
    rd(2'd2, v); chk("R8 vector empty", v, 16'h0000);
    rd(2'd0, v); chk("R8 status drained", v, 16'h0000);
  endtask

  task automatic t_vector_masked;
    logic [15:0] v;
    wr(2'd1, 16'h0008);
    pulse(7'b0001001);
    rd(2'd2, v); chk("R7 disabled arb lost skipped", v, 16'h0004);
    rd(2'd2, v); chk("R7 nothing enabled left", v, 16'h0000);
    rd(2'd0, v); chk("R8 disabled flag kept", v, 16'h0001);
    chk("R6 irq low with only disabled flag", {15'b0, irqOut}, 16'h0000);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_errors;
    logic [15:0] v;
    wr(2'd1, 16'h001F);
    pulse(7'b1100000);
    rd(2'd0, v); chk("R3 overrun and underflow bits", v, 16'h0C00);
    chk("R6 error bits do not interrupt", {15'b0, irqOut}, 16'h0000);
    rd(2'd2, v); chk("R7 error bits not vectored", v, 16'h0000);
    wr(2'd0, 16'h0400); rd(2'd0, v); chk("R4 clear underflow only", v, 16'h0800);
    wr(2'd0, 16'h0800); rd(2'd0, v); chk("R4 clear overrun", v, 16'h0000);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    busBusy = 1'b1;
    rd(2'd0, v); chk("R5 busy live high", v, 16'h1000);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R5 busy ignores write", v, 16'h1000);
    busBusy = 1'b0;
    rd(2'd0, v); chk("R5 busy live low", v, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    wr(2'd1, 16'h001F);
    pulse(7'b0000010);
    evtNoAck = 1'b1;
    wr(2'd0, 16'h0002);
    evtNoAck = 1'b0;
    rd(2'd0, v); chk("R9 event beats status clear", v, 16'h0002);
    wr(2'd0, 16'h0002);
    pulse(7'b0000001);
    evtArbLost = 1'b1;
    rd(2'd2, v); chk("R9 vector read reports arb lost", v, 16'h0001);
    evtArbLost = 1'b0;
    rd(2'd0, v); chk("R9 event beats vector clear", v, 16'h0001);
    wr(2'd0, 16'h0001);
  endtask

  task automatic t_writeback;
    logic [15:0] v;
    pulse(7'b1111111);
    rd(2'd0, v); chk("R3 all flags set", v, 16'h0C1F);
    wr(2'd0, v);
    rd(2'd0, v); chk("R4 write-back clears all", v, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    wr(2'd1, 16'h0009);
    pulse(7'b0000100);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R10 unmapped reads zero", v, 16'h0000);
    rd(2'd1, v); chk("R10 enable untouched", v, 16'h0009);
    rd(2'd0, v); chk("R10 status untouched", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_set_and_irq();
    t_vector_walk();
    t_vector_masked();
    t_errors();
    t_busy();
    t_collision();
    t_writeback();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=0x0000 expected=0x0001");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule